// File: doc/BRIEF.md
# SM3 Compression Round Engine

This block performs the 64-round SM3 compression of one 512-bit message block. It iterates a single round datapath, one round per accepted message word pair. A block starts from a 256-bit chaining value (working words A..H, with A in the most significant 32 bits). That value comes either from the `cv_in` port or, when `chain` is set, from the result of the previous block held in the block. When round 63 completes, the engine folds the final working words back onto the starting value with a bitwise XOR and presents the new chaining value on `cv_out`.

A separate expansion unit supplies the message words over a valid/ready stream. In each round it offers the expanded word Wj on `w_word` and the combined word Wj XOR Wj+4 on `w_xword`. `round_idx` tells it which j is wanted. The engine raises `w_ready` for the whole of a block. A round executes only on a cycle where `w_valid` and `w_ready` are both high. When `w_valid` is low the engine waits and keeps its working state, so the producer can apply back-pressure at any round. Words offered while the engine is idle are never consumed. Round constants are produced inside the block. Padding, length encoding and message buffering belong to the surrounding logic.

Top module: `sm3_round_core`

## Requirements
- R1: After reset `busy` and `done` are 0, `w_ready` is 0, `round_idx` is 0, and `cv_out` holds the standard initial value 7380166F 4914B2B9 172442D7 DA8A0600 A96F30BC 163138AA E38DEE4D B0FB0E4E (A first, A in bits 255:224).
- R2: A `start` pulse while idle with `chain` = 0 loads `cv_in`. Once 64 rounds are done, `cv_out` equals the SM3 compression of that value with the block, and the result is the XOR of the final working words with the starting value. For the padded one-block message "abc" (word 0 = 61626380, word 15 = 00000018, all others 0) starting from the initial value, the result is 66C7F0F4 62EEEDD9 D1F2D46B DC10E4E2 4167C487 5CF2F7A2 297DA02B 8F4BA8E0.
- R3: A `start` with `chain` = 1 takes the current `cv_out` as the starting value and ignores `cv_in`. Directly after reset, this is the initial value.
- R4: `w_ready` is high exactly while `busy`. A round advances only on a cycle with `w_valid` and `w_ready` both high. `round_idx` runs 0..63 through the block and rests at 0 while idle. Words offered on stalled cycles have no effect on the result.
- R5: `done` is high for exactly one cycle, the cycle after the 64th accepted word pair. `busy` falls in that same cycle, and `cv_out` already holds the new value.
- R6: `start` is ignored while `busy`. It changes neither the source nor the progress of the block in flight.
- R7: `cv_out` changes only in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block when idle |
| chain | input | 1 | 1: start from `cv_out`; 0: start from `cv_in` |
| cv_in | input | 256 | Starting chaining value, A in bits 255:224 |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle completion pulse |
| cv_out | output | 256 | Resulting chaining value |
| w_valid | input | 1 | Message word pair offered |
| w_ready | output | 1 | Engine accepts a word pair |
| w_word | input | 32 | Expanded word Wj |
| w_xword | input | 32 | Wj XOR Wj+4 |
| round_idx | output | 6 | Index j of the word pair wanted |

## Verification
The checker watches the control timing on every cycle. It checks that `done` never lasts two cycles and is always preceded by a busy cycle. It checks that a stalled cycle freezes `round_idx`, that every accepted pair steps the index by one, that `round_idx` is 0 while idle, that `start` cannot end a block early, and that `cv_out` moves only together with `done`. The arithmetic of the rounds, meaning the boolean function switch at round 16, the rotated constants, P0 and the XOR feed-forward, can only be shown by the bench's scenarios. These compare complete results against a known answer and against an independent model. The scenarios cover stall patterns, chaining from reset and from a previous block, and a start injected mid-block.

// File: rtl/sm3_pkg.sv
package sm3_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 8;
  localparam int STATE_W   = WORD_W * NUM_WORDS;
  localparam int ROUNDS    = 64;
  localparam int ROUND_W   = $clog2(ROUNDS);
  localparam int MIX_ROUND = 16;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
    word_t f;
    word_t g;
    word_t h;
  } state_t;

  localparam logic [STATE_W-1:0] SM3_IV =
    256'h7380166f_4914b2b9_172442d7_da8a0600_a96f30bc_163138aa_e38dee4d_b0fb0e4e;

  localparam word_t T_EARLY = 32'h79cc4519;
  localparam word_t T_LATE  = 32'h7a879d8a;

  function automatic word_t rotl(input word_t x, input int unsigned n);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} << (n % WORD_W);
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

  function automatic word_t perm0(input word_t x);
    return x ^ rotl(x, 9) ^ rotl(x, 17);
  endfunction
endpackage

// File: rtl/sm3_tconst.sv
module sm3_tconst
  import sm3_pkg::*;
#(
  parameter int RW = ROUND_W
) (
  input  logic [RW-1:0] round,
  output word_t         t_rot
);
  localparam int SH_W = $clog2(WORD_W);

  word_t base;
  word_t stage [0:SH_W];

  assign base     = (int'(round) < MIX_ROUND) ? T_EARLY : T_LATE;
  assign stage[0] = base;

  for (genvar k = 0; k < SH_W; k++) begin : g_rot
    assign stage[k+1] = round[k] ? rotl(stage[k], 1 << k) : stage[k];
  end

  assign t_rot = stage[SH_W];
endmodule

// File: rtl/sm3_round_step.sv
module sm3_round_step
  import sm3_pkg::*;
(
  input  state_t cur,
  input  word_t  wj,
  input  word_t  wpj,
  input  word_t  tj,
  input  logic   late,
  output state_t nxt
);
  word_t a_rot;
  word_t ss1;
  word_t ss2;
  word_t ff;
  word_t gg;
  word_t tt1;
  word_t tt2;

  always_comb begin
    a_rot = rotl(cur.a, 12);
    ss1   = rotl(a_rot + cur.e + tj, 7);
    ss2   = ss1 ^ a_rot;
    if (late) begin
      ff = (cur.a & cur.b) | (cur.a & cur.c) | (cur.b & cur.c);
      gg = ((cur.f ^ cur.g) & cur.e) ^ cur.g;
    end else begin
      ff = cur.a ^ cur.b ^ cur.c;
      gg = cur.e ^ cur.f ^ cur.g;
    end
    tt1 = ff + cur.d + ss2 + wpj;
    tt2 = gg + cur.h + ss1 + wj;

    nxt.a = tt1;
    nxt.b = cur.a;
    nxt.c = rotl(cur.b, 9);
    nxt.d = cur.c;
    nxt.e = perm0(tt2);
    nxt.f = cur.e;
    nxt.g = rotl(cur.f, 19);
    nxt.h = cur.g;
  end
endmodule

// File: rtl/sm3_seq_ctrl.sv
module sm3_seq_ctrl
  import sm3_pkg::*;
#(
  parameter int NR = ROUNDS,
  parameter int RW = ROUND_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          w_valid,
  output logic          busy,
  output logic          load,
  output logic          step,
  output logic          finish,
  output logic          done,
  output logic [RW-1:0] round
);
  localparam logic [RW-1:0] LAST = RW'(NR - 1);

  assign load   = start & ~busy;
  assign step   = busy & w_valid;
  assign finish = step & (round == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      round <= '0;
    end else begin
      done <= finish;
      if (load) begin
        busy  <= 1'b1;
        round <= '0;
      end else if (step) begin
        if (round == LAST) begin
          busy  <= 1'b0;
          round <= '0;
        end else begin
          round <= round + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sm3_round_core.sv
module sm3_round_core
  import sm3_pkg::*;
#(
  parameter logic [STATE_W-1:0] INIT_CV = SM3_IV
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               chain,
  input  logic [STATE_W-1:0] cv_in,
  output logic               busy,
  output logic               done,
  output logic [STATE_W-1:0] cv_out,
  input  logic               w_valid,
  output logic               w_ready,
  input  logic [WORD_W-1:0]  w_word,
  input  logic [WORD_W-1:0]  w_xword,
  output logic [ROUND_W-1:0] round_idx
);
  logic   load;
  logic   step;
  logic   finish;
  word_t  tj;
  state_t work_q;
  state_t base_q;
  state_t next_s;
  state_t src;
  logic [STATE_W-1:0] cv_q;

  sm3_seq_ctrl #(.NR(ROUNDS), .RW(ROUND_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .w_valid (w_valid),
    .busy    (busy),
    .load    (load),
    .step    (step),
    .finish  (finish),
    .done    (done),
    .round   (round_idx)
  );

  sm3_tconst #(.RW(ROUND_W)) tconst_i (
    .round (round_idx),
    .t_rot (tj)
  );

  sm3_round_step step_i (
    .cur  (work_q),
    .wj   (w_word),
    .wpj  (w_xword),
    .tj   (tj),
    .late (int'(round_idx) >= MIX_ROUND),
    .nxt  (next_s)
  );

  assign src     = chain ? state_t'(cv_q) : state_t'(cv_in);
  assign w_ready = busy;
  assign cv_out  = cv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_q <= '0;
      base_q <= '0;
      cv_q   <= INIT_CV;
    end else begin
      if (load) begin
        work_q <= src;
        base_q <= src;
      end else if (step) begin
        work_q <= next_s;
      end
      if (finish) begin
        cv_q <= next_s ^ base_q;
      end
    end
  end
endmodule

// File: rtl/sm3_round_core_chk.sv
module sm3_round_core_chk
  import sm3_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [STATE_W-1:0] cv_out,
  input logic               w_valid,
  input logic [ROUND_W-1:0] round_idx
);
  localparam logic [ROUND_W-1:0] LAST = ROUND_W'(ROUNDS - 1);

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !w_valid) |=> (busy && $stable(round_idx)));

  // R4
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && w_valid) |=> (done || round_idx == ROUND_W'($past(round_idx) + 1'b1)));

  // R4
  idle_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (round_idx == '0));

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(w_valid && round_idx == LAST)) |=> busy);

  // R7
  cv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(cv_out));
endmodule

bind sm3_round_core sm3_round_core_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .cv_out    (cv_out),
  .w_valid   (w_valid),
  .round_idx (round_idx)
);

// File: tb/sm3_round_core_tb.sv
module sm3_round_core_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         chain = 1'b0;
  logic [255:0] cv_in = '0;
  logic         busy;
  logic         done;
  logic [255:0] cv_out;
  logic         w_valid = 1'b0;
  logic         w_ready;
  logic [31:0]  w_word = '0;
  logic [31:0]  w_xword = '0;
  logic [5:0]   round_idx;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic [31:0]  wexp [0:67];
  logic [255:0] iv_ref  = 256'h7380166f_4914b2b9_172442d7_da8a0600_a96f30bc_163138aa_e38dee4d_b0fb0e4e;
  logic [255:0] kat_abc = 256'h66c7f0f4_62eeedd9_d1f2d46b_dc10e4e2_4167c487_5cf2f7a2_297da02b_8f4ba8e0;
  logic [511:0] blk_abc = {32'h61626380, 448'h0, 32'h00000018};

  always #10 clk = ~clk;

  sm3_round_core dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .chain     (chain),
    .cv_in     (cv_in),
    .busy      (busy),
    .done      (done),
    .cv_out    (cv_out),
    .w_valid   (w_valid),
    .w_ready   (w_ready),
    .w_word    (w_word),
    .w_xword   (w_xword),
    .round_idx (round_idx)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (n == 0) ? x : ((x << n) | (x >> (32 - n)));
  endfunction

  task automatic expand(input logic [511:0] blk);
    for (int i = 0; i < 16; i++) wexp[i] = blk[511 - 32*i -: 32];
    for (int i = 16; i < 68; i++) begin
      logic [31:0] t;
      t = wexp[i-16] ^ wexp[i-9] ^ rl(wexp[i-3], 15);
      wexp[i] = (t ^ rl(t, 15) ^ rl(t, 23)) ^ rl(wexp[i-13], 7) ^ wexp[i-6];
    end
  endtask

  function automatic logic [255:0] model(input logic [255:0] v, input logic [511:0] blk);
    logic [31:0] w [0:67];
    logic [31:0] r [0:7];
    for (int i = 0; i < 16; i++) w[i] = blk[511 - 32*i -: 32];
    for (int i = 16; i < 68; i++) begin
      logic [31:0] t;
      t = w[i-16] ^ w[i-9] ^ rl(w[i-3], 15);
      w[i] = (t ^ rl(t, 15) ^ rl(t, 23)) ^ rl(w[i-13], 7) ^ w[i-6];
    end
    for (int i = 0; i < 8; i++) r[i] = v[255 - 32*i -: 32];
    for (int j = 0; j < 64; j++) begin
      logic [31:0] tc, s1, s2, f1, g1, t1, t2;
      tc = rl((j < 16) ? 32'h79cc4519 : 32'h7a879d8a, j % 32);
      s1 = rl(rl(r[0], 12) + r[4] + tc, 7);
      s2 = s1 ^ rl(r[0], 12);
      f1 = (j < 16) ? (r[0] ^ r[1] ^ r[2]) : ((r[0] & r[1]) | (r[0] & r[2]) | (r[1] & r[2]));
      g1 = (j < 16) ? (r[4] ^ r[5] ^ r[6]) : ((r[4] & r[5]) | (~r[4] & r[6]));
      t1 = f1 + r[3] + s2 + (w[j] ^ w[j+4]);
      t2 = g1 + r[7] + s1 + w[j];
      r[3] = r[2]; r[2] = rl(r[1], 9); r[1] = r[0]; r[0] = t1;
      r[7] = r[6]; r[6] = rl(r[5], 19); r[5] = r[4];
      r[4] = t2 ^ rl(t2, 9) ^ rl(t2, 17);
    end
    return {r[0], r[1], r[2], r[3], r[4], r[5], r[6], r[7]} ^ v;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_block(input logic [255:0] cv, input logic ch, input logic [511:0] blk,
                           input int stall, input logic inject, input logic [255:0] exp,
                           input string tag);
    int j = 0;
    int cyc = 0;
    logic [255:0] held;
    expand(blk);
    @(negedge clk);
    cv_in = cv; chain = ch; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cv_in = ~cv; chain = ~ch;
    held = cv_out;
    chk(busy === 1'b1, "R4 busy after start", 256'(busy), 256'(1));
    while (j < 64) begin
      chk(round_idx === 6'(j), "R4 round index", 256'(round_idx), 256'(j));
      chk(done === 1'b0, "R5 no early done", 256'(done), 256'(0));
      chk(cv_out === held, "R7 cv_out held mid-block", cv_out, held);
      if (inject && j == 20) begin
        start = 1'b1; cv_in = 256'hdead_beef; chain = ~ch;
      end else begin
        start = 1'b0;
      end
      w_valid = !(stall > 0 && (cyc % stall) == 0);
      if (w_valid) begin
        w_word = wexp[j]; w_xword = wexp[j] ^ wexp[j+4];
      end else begin
        w_word = 32'hffff_0000 ^ 32'(cyc); w_xword = ~w_word;
      end
      if (w_valid && w_ready) j++;
      cyc++;
      @(negedge clk);
    end
    w_valid = 1'b0; start = 1'b0;
    chk(done === 1'b1, {"R5 done pulse ", tag}, 256'(done), 256'(1));
    chk(busy === 1'b0, {"R5 busy falls ", tag}, 256'(busy), 256'(0));
    chk(cv_out === exp, {tag, " result"}, cv_out, exp);
    @(negedge clk);
    chk(done === 1'b0, {"R5 done one cycle ", tag}, 256'(done), 256'(0));
    chk(cv_out === exp, {"R7 cv_out stable ", tag}, cv_out, exp);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R1 busy", 256'(busy), 256'(0));
    chk(done === 1'b0, "R1 done", 256'(done), 256'(0));
    chk(w_ready === 1'b0, "R1 w_ready", 256'(w_ready), 256'(0));
    chk(round_idx === 6'd0, "R1 round_idx", 256'(round_idx), 256'(0));
    chk(cv_out === iv_ref, "R1 cv_out", cv_out, iv_ref);
  endtask

  task automatic test_idle_hold();
    logic [255:0] held = cv_out;
    for (int i = 0; i < 12; i++) begin
      cv_in = {8{32'(i) * 32'h01010101}}; chain = i[0]; w_valid = 1'b1;
      w_word = 32'(i); w_xword = ~32'(i);
      @(negedge clk);
      chk(cv_out === held, "R7 idle cv_out", cv_out, held);
      chk(busy === 1'b0 && round_idx === 6'd0, "R4 idle words ignored",
          256'({busy, round_idx}), 256'(0));
    end
    w_valid = 1'b0;
  endtask

  initial begin
    logic [255:0] cv_a;
    logic [511:0] blk_b;
    logic [255:0] r1;
    test_reset();
    // R3: chain right after reset uses the initial value
    run_block(256'h1111_2222, 1'b1, blk_abc, 0, 1'b0, kat_abc, "R3 chain from reset");
    // R2: known answer from cv_in
    run_block(iv_ref, 1'b0, blk_abc, 0, 1'b0, kat_abc, "R2 known answer");
    // R4: stalls on every third cycle
    cv_a  = 256'h0123456789abcdef_fedcba9876543210_a5a5a5a55a5a5a5a_0f0f0f0ff0f0f0f0;
    blk_b = {16{32'h9e3779b9}} ^ {64{8'h3c}};
    r1 = model(cv_a, blk_b);
    run_block(cv_a, 1'b0, blk_b, 3, 1'b0, r1, "R4 stalled block");
    // R3: second block chained from the previous result
    run_block(256'h0, 1'b1, blk_abc, 2, 1'b0, model(r1, blk_abc), "R3 chained block");
    // R6: start raised mid-block
    run_block(iv_ref, 1'b0, blk_b, 0, 1'b1, model(iv_ref, blk_b), "R6 start while busy");
    test_idle_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule